// File: doc/BRIEF.md
# Randomized 16-Point Hadamard Transform

This block is a streaming preconditioner that sits in front of a narrow-format quantizer. It takes a vector of sixteen signed fixed-point samples and negates selected elements according to a hardwired sign pattern. It then mixes the vector through a four-stage add/subtract butterfly network and scales the result by one quarter. The combined operation is an orthonormal 16×16 Hadamard matrix preceded by a diagonal ±1 matrix. Large values that sit in a few elements are spread across all sixteen outputs, so one block scale covers the whole vector with less underflow. The sign pattern defeats the rare case where an outlier lines up with a row of the plain Hadamard matrix.

Vectors enter and leave over valid/ready handshakes, one whole vector per transfer. Each butterfly stage and the rounded output have their own register, so the block accepts a new vector every cycle while the output side is ready. When the output side stalls, the whole pipeline freezes. The sign pattern is a parameter and is the same for every vector. The output is three bits wider than the input, so no input value can overflow.

Top module: `rand_hadamard16`

## Requirements
- R1: Element i of a vector is carried on bits [i*W +: W] of its bus, where W is the element width. Output element k equals round(Σj (−1)^popcount(j AND k) · sj · xj / 4), where xj is input element j read as two's complement and sj is its sign factor.
- R2: Bit i of the `SIGN_MASK` parameter set to 1 makes si = −1, and cleared makes si = +1. The same pattern applies to every vector. A single nonzero input value 4 at element j therefore yields ±1 on every output, with the sign of output 0 equal to −1 exactly when bit j is set.
- R3: The division by 4 rounds to nearest, with exact halves going to the even neighbour. For example −0.5 → 0, 1.5 → 2, 2.5 → 2, 3.5 → 4 and −1.5 → −2.
- R4: The output elements are DATA_W+3 bits wide, in two's complement. No input vector, including all-minimum and sign-aligned full-scale inputs, makes an output wrap. Every output magnitude stays at or below 2^(DATA_W+1).
- R5: With `outReady` held high, a vector accepted on a clock edge appears on `outData` with `outValid` high after the fifth rising edge, counting the accepting edge as the first.
- R6: With `outReady` held high, `inReady` stays high. Vectors presented on consecutive cycles leave on consecutive cycles, in order.
- R7: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values. The block absorbs at most five vectors and then drops `inReady`. After release, every accepted vector leaves exactly once and in order, including a vector accepted on the same edge as the release.
- R8: Synchronous active-high `rst` empties the pipeline. In the first cycle after reset, `outValid` is low and `inReady` is high, even if vectors were in flight when reset was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An input vector is offered |
| inReady | output | 1 | The block takes the offered vector on this edge |
| inData | input | 16*DATA_W | Sixteen signed input elements, element i at bits [i*DATA_W +: DATA_W] |
| outValid | output | 1 | A transformed vector is presented |
| outReady | input | 1 | The consumer takes the presented vector on this edge |
| outData | output | 16*(DATA_W+3) | Sixteen signed output elements, element k at bits [k*(DATA_W+3) +: DATA_W+3] |

## Verification
Two functions can fall on the same clock edge: a stalled output can be released, and a new vector can enter the head of the pipeline. The bench fills the pipeline with `outReady` low until `inReady` drops, then raises `outReady` while a further vector is still offered. The held output then leaves on the same edge as the new vector enters. This is judged by a scoreboard that expects every output in acceptance order, each computed from the transform formula. A final check confirms the scoreboard is empty, so no vector was dropped or repeated.

// File: rtl/rht_pkg.sv
`timescale 1ns/1ps
package rht_pkg;
  // Transform size; must be a power of two with an even number of stages
  localparam int unsigned RHT_N          = 16;
  localparam int unsigned RHT_STAGES     = $clog2(RHT_N);
  // One register per butterfly stage plus the rounded output register
  localparam int unsigned RHT_LEVELS     = RHT_STAGES + 1;
  // 1/sqrt(2) per stage gives 2^-(stages/2) overall
  localparam int unsigned RHT_NORM_SHIFT = RHT_STAGES / 2;

  // Strobes from the control to the datapath: load enable per register level
  typedef struct packed {
    logic [RHT_LEVELS-1:0] load;
  } rht_strobe_t;
endpackage

// File: rtl/rht_ctrl.sv
`timescale 1ns/1ps
module rht_ctrl
  import rht_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output rht_strobe_t strobe
);

  logic [RHT_LEVELS-1:0] validQ;
  logic                  advance;

  // The pipeline moves as one piece unless a full output is being held
  assign advance  = !validQ[RHT_LEVELS-1] || outReady;
  assign inReady  = advance;
  assign outValid = validQ[RHT_LEVELS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (advance) begin
      validQ <= {validQ[RHT_LEVELS-2:0], inValid};
    end
  end

  // Only levels that receive a real vector are loaded
  always_comb begin
    strobe.load[0] = advance && inValid;
    for (int k = 1; k < RHT_LEVELS; k++) begin
      strobe.load[k] = advance && validQ[k-1];
    end
  end

  // R7: a presented vector stays presented until taken
  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid)
    else $error("outValid dropped during a stall");

  // R8: first cycle after reset shows an empty pipeline
  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady))
    else $error("pipeline not empty after reset");

endmodule

// File: rtl/rht_datapath.sv
`timescale 1ns/1ps
module rht_datapath
  import rht_pkg::*;
#(
  parameter  int unsigned     DATA_W    = 12,
  parameter  logic [RHT_N-1:0] SIGN_MASK = '0,
  localparam int unsigned     INNER_W   = DATA_W + RHT_STAGES + 1,
  localparam int unsigned     OUT_W     = INNER_W - RHT_NORM_SHIFT
)(
  input  logic                     clk,
  input  logic                     rst,
  input  rht_strobe_t              strobe,
  input  logic [RHT_N*DATA_W-1:0]  inData,
  output logic [RHT_N*OUT_W-1:0]   outData
);

  // Largest magnitude any output can take: 2^(DATA_W-1) * N / 2^shift
  localparam int OUT_LIMIT = 1 << (DATA_W - 1 + RHT_STAGES - RHT_NORM_SHIFT);

  // lvl[0] is the sign-flipped input; lvl[s+1] is the register after stage s
  logic [RHT_STAGES:0][RHT_N*INNER_W-1:0] lvl;
  logic [RHT_N*OUT_W-1:0]                 rounded;
  logic [RHT_N*OUT_W-1:0]                 outReg;

  // Sign extension to the full inner width, then the fixed sign flip.
  // Widening first keeps the negation of the most negative input exact.
  for (genvar i = 0; i < RHT_N; i++) begin : g_sign
    logic [INNER_W-1:0] widened;
    assign widened = INNER_W'(signed'(inData[i*DATA_W +: DATA_W]));
    if (SIGN_MASK[i]) begin : g_neg
      assign lvl[0][i*INNER_W +: INNER_W] = -widened;
    end else begin : g_pos
      assign lvl[0][i*INNER_W +: INNER_W] = widened;
    end
  end

  // Butterfly stage s pairs elements whose indices differ only in bit s
  for (genvar s = 0; s < RHT_STAGES; s++) begin : g_stage
    localparam int unsigned SPAN = 1 << s;
    logic [RHT_N*INNER_W-1:0] mixed;
    logic [RHT_N*INNER_W-1:0] held;

    for (genvar i = 0; i < RHT_N; i++) begin : g_elem
      if (((i >> s) & 1) == 0) begin : g_sum
        assign mixed[i*INNER_W +: INNER_W] =
          lvl[s][i*INNER_W +: INNER_W] + lvl[s][(i+SPAN)*INNER_W +: INNER_W];
      end else begin : g_diff
        assign mixed[i*INNER_W +: INNER_W] =
          lvl[s][(i-SPAN)*INNER_W +: INNER_W] - lvl[s][i*INNER_W +: INNER_W];
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.load[s]) begin
        held <= mixed;
      end
    end

    assign lvl[s+1] = held;
  end

  // Normalising shift with round-half-even
  for (genvar i = 0; i < RHT_N; i++) begin : g_round
    logic [INNER_W-1:0] sumVal;
    logic [OUT_W-1:0]   trunc;
    logic               halfBit;
    logic               stickyBits;
    logic               bumpUp;

    assign sumVal     = lvl[RHT_STAGES][i*INNER_W +: INNER_W];
    assign trunc      = sumVal[INNER_W-1:RHT_NORM_SHIFT];
    assign halfBit    = sumVal[RHT_NORM_SHIFT-1];
    assign stickyBits = |sumVal[RHT_NORM_SHIFT-2:0];
    assign bumpUp     = halfBit && (stickyBits || trunc[0]);
    assign rounded[i*OUT_W +: OUT_W] = trunc + OUT_W'(bumpUp);

    // R4: a freshly loaded output never exceeds the bound for full-scale inputs
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
      strobe.load[RHT_STAGES] |=>
        (($signed(outReg[i*OUT_W +: OUT_W]) <= OUT_LIMIT) &&
         ($signed(outReg[i*OUT_W +: OUT_W]) >= -OUT_LIMIT)))
      else $error("output element out of range");
  end

  always_ff @(posedge clk) begin
    if (strobe.load[RHT_STAGES]) begin
      outReg <= rounded;
    end
  end

  assign outData = outReg;

endmodule

// File: rtl/rand_hadamard16.sv
`timescale 1ns/1ps
module rand_hadamard16
  import rht_pkg::*;
#(
  parameter  int unsigned      DATA_W    = 12,
  parameter  logic [RHT_N-1:0] SIGN_MASK = 16'h9A35,
  localparam int unsigned      OUT_W     = DATA_W + RHT_STAGES + 1 - RHT_NORM_SHIFT
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [RHT_N*DATA_W-1:0] inData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [RHT_N*OUT_W-1:0]  outData
);

  rht_strobe_t strobe;

  rht_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  rht_datapath #(
    .DATA_W    (DATA_W),
    .SIGN_MASK (SIGN_MASK)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

  // R7: the presented data does not change while the consumer stalls
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> $stable(outData))
    else $error("outData changed during a stall");

endmodule

// File: tb/rand_hadamard16_bench.sv
`timescale 1ns/1ps
module rand_hadamard16_bench;

  localparam int N  = 16;
  localparam int DW = 12;
  localparam int OW = DW + 3;
  localparam logic [N-1:0] SIGNS = 16'h9A35;

  // Stimulus table: element j = base + step*j, with every third element's step negated
  localparam int TBL_LEN = 8;
  localparam int TBL_BASE [TBL_LEN] = '{0, 100, 0, -2048, 2047, 5, -300, 1234};
  localparam int TBL_STEP [TBL_LEN] = '{0, 0, 37, 256, -273, 1, 97, -511};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic outReady = 1'b1;
  logic [N*DW-1:0] inData = '0;
  logic inReady;
  logic outValid;
  logic [N*OW-1:0] outData;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  logic [N*OW-1:0] expQ[$];
  logic [N*OW-1:0] monExp;
  int runLen = 0;
  int maxRun = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rand_hadamard16 #(.DATA_W(DW), .SIGN_MASK(SIGNS)) u_rand_hadamard16 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  // Reference transform computed from the requirement formula
  function automatic logic [N*OW-1:0] refVec(input logic [N*DW-1:0] x);
    logic [N*OW-1:0] r;
    int acc, e, q, rem;
    r = '0;
    for (int k = 0; k < N; k++) begin
      acc = 0;
      for (int j = 0; j < N; j++) begin
        e = int'(signed'(x[j*DW +: DW]));
        if (SIGNS[j]) e = -e;
        if (($countones(j & k) % 2) == 1) acc = acc - e;
        else acc = acc + e;
      end
      q = acc >>> 2;
      rem = acc & 3;
      if (rem > 2 || (rem == 2 && (q & 1) == 1)) q = q + 1;
      r[k*OW +: OW] = q[OW-1:0];
    end
    return r;
  endfunction

  function automatic logic [N*DW-1:0] genVec(input int base, input int step);
    logic [N*DW-1:0] v;
    int val;
    for (int j = 0; j < N; j++) begin
      val = base + step * j * (((j % 3) == 1) ? -1 : 1);
      v[j*DW +: DW] = val[DW-1:0];
    end
    return v;
  endfunction

  function automatic logic [N*DW-1:0] impulse(input int pos, input int val);
    logic [N*DW-1:0] v;
    v = '0;
    v[pos*DW +: DW] = val[DW-1:0];
    return v;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard: sampled mid-cycle, inputs change just after the rising edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (outValid && outReady) begin
        runLen++;
        if (runLen > maxRun) maxRun = runLen;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected output: got %h expected none", curReq, outData);
        end else begin
          monExp = expQ.pop_front();
          if (outData !== monExp) begin
            errors++;
            $display("FAIL %s output vector: got %h expected %h", curReq, outData, monExp);
          end
        end
      end else begin
        runLen = 0;
      end
      if (inValid && inReady) expQ.push_back(refVec(inData));
    end
  end

  task automatic sendOne(input logic [N*DW-1:0] v, output logic [N*OW-1:0] got, output int lat);
    @(posedge clk); #1;
    inValid = 1'b1;
    inData  = v;
    @(posedge clk); #1;
    inValid = 1'b0;
    lat = 1;
    @(negedge clk);
    while (!outValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    got = outData;
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [N*OW-1:0] got;
    logic [N*DW-1:0] v;
    logic [N*OW-1:0] held;
    int lat;
    int accepted;
    bit acc;

    // R8: reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R8", "outValid after reset", outValid, 0);
    check("R8", "inReady after reset", inReady, 1);

    // R1 and R5: table walk, one isolated vector at a time
    curReq = "R1";
    for (int t = 0; t < TBL_LEN; t++) begin
      v = genVec(TBL_BASE[t], TBL_STEP[t]);
      sendOne(v, got, lat);
      check("R5", "latency in edges", lat, 5);
      checks++;
      if (got !== refVec(v)) begin
        errors++;
        $display("FAIL R1 table entry %0d: got %h expected %h", t, got, refVec(v));
      end
    end

    // R2: impulse of 4 at each position; output 0 is -1 where the sign bit is set
    curReq = "R2";
    for (int j = 0; j < N; j++) begin
      sendOne(impulse(j, 4), got, lat);
      check("R2", $sformatf("impulse sign at element %0d", j),
            longint'($signed(got[OW-1:0])), SIGNS[j] ? -1 : 1);
    end

    // R3: rounding of quarter values at element 0 (sign bit 0 is set, so value is -x/4)
    curReq = "R3";
    sendOne(impulse(0, 2), got, lat);
    check("R3", "-0.5 rounds to 0", longint'($signed(got[OW-1:0])), 0);
    sendOne(impulse(0, -6), got, lat);
    check("R3", "1.5 rounds to 2", longint'($signed(got[OW-1:0])), 2);
    sendOne(impulse(0, -10), got, lat);
    check("R3", "2.5 rounds to 2", longint'($signed(got[OW-1:0])), 2);
    sendOne(impulse(0, -14), got, lat);
    check("R3", "3.5 rounds to 4", longint'($signed(got[OW-1:0])), 4);
    sendOne(impulse(0, 6), got, lat);
    check("R3", "-1.5 rounds to -2", longint'($signed(got[OW-1:0])), -2);
    sendOne(impulse(0, -5), got, lat);
    check("R3", "1.25 rounds to 1", longint'($signed(got[OW-1:0])), 1);

    // R4: full-scale inputs aligned with the sign pattern (mask has 8 set bits)
    curReq = "R4";
    for (int j = 0; j < N; j++) v[j*DW +: DW] = SIGNS[j] ? 12'h800 : 12'h7FF;
    sendOne(v, got, lat);
    check("R4", "positive full-scale sum", longint'($signed(got[OW-1:0])), 8190);
    for (int j = 0; j < N; j++) v[j*DW +: DW] = SIGNS[j] ? 12'h7FF : 12'h800;
    sendOne(v, got, lat);
    check("R4", "negative full-scale sum", longint'($signed(got[OW-1:0])), -8190);
    sendOne(genVec(-2048, 0), got, lat);
    check("R4", "all-minimum vector", (got === refVec(genVec(-2048, 0))) ? 1 : 0, 1);

    // R6: back-to-back burst
    curReq = "R6";
    maxRun = 0;
    for (int t = 0; t < 8; t++) begin
      @(posedge clk); #1;
      inValid = 1'b1;
      inData  = genVec(t * 111 - 400, 13 * t + 1);
      @(negedge clk);
      check("R6", "inReady during burst", inReady, 1);
    end
    @(posedge clk); #1 inValid = 1'b0;
    repeat (10) @(negedge clk);
    check("R6", "consecutive outputs", maxRun, 8);

    // R7: stall, fill, then release on the same edge as a new acceptance
    curReq = "R7";
    @(posedge clk); #1 outReady = 1'b0;
    accepted = 0;
    inData = genVec(accepted * 57 - 900, accepted + 3);
    inValid = 1'b1;
    for (int t = 0; t < 9; t++) begin
      @(negedge clk);
      acc = inReady;
      @(posedge clk); #1;
      if (acc) begin
        accepted++;
        inData = genVec(accepted * 57 - 900, accepted + 3);
      end
    end
    check("R7", "vectors absorbed while stalled", accepted, 5);
    @(negedge clk);
    held = outData;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      check("R7", "outValid held", outValid, 1);
      check("R7", "outData held", (outData === held) ? 1 : 0, 1);
      check("R7", "inReady low when full", inReady, 0);
    end
    @(posedge clk); #1 outReady = 1'b1;
    @(negedge clk);
    check("R7", "new vector taken on release edge", inReady, 1);
    @(posedge clk); #1 inValid = 1'b0;
    repeat (10) @(negedge clk);
    check("R7", "scoreboard drained", expQ.size(), 0);

    // R8: reset with vectors in flight
    curReq = "R8";
    @(posedge clk); #1 outReady = 1'b0;
    inValid = 1'b1;
    inData = genVec(77, 5);
    repeat (3) @(posedge clk);
    #1 inValid = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    expQ.delete();
    rst = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    check("R8", "outValid after mid-run reset", outValid, 0);
    check("R8", "inReady after mid-run reset", inReady, 1);
    sendOne(genVec(-17, 29), got, lat);
    check("R8", "first vector after reset", (got === refVec(genVec(-17, 29))) ? 1 : 0, 1);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule